// File: doc/BRIEF.md
# Runtime-Programmable Event Trigger Manager

This block watches a group of monitored ports of a device under test, both its inputs and its outputs, without driving any of them. A set of comparators, each set up by the host at run time, compares one chosen port against a programmed operand. Each comparator produces one event bit. A set of conditions then joins those events through boolean logic. When a condition becomes true, the block carries out the action programmed for it: it starts the recorder, stops the recorder, loads a new sampling-rate code, or switches the device to another parameter set.

The host programs every comparator and condition through a simple write-only register port. A comparator uses two words: a control word at address 2*i and an operand at address 2*i+1. Condition j uses one word at address 2*NUM_CMP+j. In the comparator control word, bits [2:0] hold the opcode, bit 3 selects signed mode, and the bits from bit 4 upward hold the port index. In the condition word, bits [NUM_CMP-1:0] hold the event mask, bit 4 selects OR mode (it is AND when clear), bit 5 inverts the result, bits [7:6] hold the action, and bits [15:8] hold the action argument.

Top module: `etm_trigger_manager`

## Requirements
- R1: While reset is held and after its release, rec_active is 0, rate_sel is 0, pset_sel is 0 and cond_pulse is all zeros.
- R2: The comparator opcodes are 001 equal, 010 not equal, 011 port below operand, 100 port above operand, 101 port at or below operand and 110 port at or above operand. Opcodes 000 and 111 never raise the event.
- R3: When control bit 3 is set, the comparison treats the port value and the operand as two's complement. When it is clear, both are unsigned.
- R4: The control field from bit 4 upward selects which monitored port the comparator uses. Port p occupies bits [p*PORT_W +: PORT_W] of mon_ports.
- R5: In AND mode (bit 4 = 0) a condition is true when every masked event is set. In OR mode (bit 4 = 1) it is true when any masked event is set. A condition whose mask is zero is never true, whatever the invert bit says.
- R6: The invert bit (bit 5) complements the result of a condition that has a nonzero mask.
- R7: A condition acts only on its rising edge. cond_pulse[j] is high for exactly one cycle each time condition j goes from false to true, and a condition that stays true gives no further pulse.
- R8: A port value present before clock edge k updates the event at edge k. The resulting cond_pulse and action outputs change at edge k+1 and not earlier.
- R9: Action 00 sets rec_active and action 01 clears it. If both fire on the same edge, the clear takes effect.
- R10: Action 10 loads rate_sel from the low bits of the argument. If several conditions fire this action together, the lowest-numbered one wins. rate_sel changes only on an edge where some cond_pulse bit rises.
- R11: Action 11 loads pset_sel from the low bits of the argument, with the whole field changing on one edge. If several conditions fire this action together, the lowest-numbered one wins.
- R12: Writes to addresses at or above 2*NUM_CMP+NUM_COND change no comparator or condition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Register write address |
| cfg_wdata | input | CFG_W | Register write data |
| mon_ports | input | NUM_PORTS*PORT_W | Monitored device ports, packed |
| cond_pulse | output | NUM_COND | One-cycle pulse per condition rising edge |
| rec_active | output | 1 | Recorder run state |
| rate_sel | output | RATE_W | Selected sampling-rate code |
| pset_sel | output | PSET_W | Selected parameter set |

## Verification
Each opcode is tried with operand pairs that sit on both sides of equality, including the equal case. This separates the strict comparisons from the inclusive ones. A single value with its top bit set is compared in both signed and unsigned modes, which exposes a missing sign handling. The combining logic is driven with one event set and with both set, which separates AND from OR, and with an empty mask under inversion. A held condition, two conditions firing at once and writes to unmapped addresses show edge detection, action priority and decode containment. The one-edge gap between an event and its pulse is sampled on both sides.

// File: rtl/etm_pkg.sv
package etm_pkg;
   localparam logic [2:0] OP_OFF = 3'b000;
   localparam logic [2:0] OP_EQ  = 3'b001;
   localparam logic [2:0] OP_NE  = 3'b010;
   localparam logic [2:0] OP_LT  = 3'b011;
   localparam logic [2:0] OP_GT  = 3'b100;
   localparam logic [2:0] OP_LE  = 3'b101;
   localparam logic [2:0] OP_GE  = 3'b110;

   typedef enum logic [1:0] {
      ACT_START = 2'b00,
      ACT_STOP  = 2'b01,
      ACT_RATE  = 2'b10,
      ACT_PSET  = 2'b11
   } etm_act_e;

   localparam int ARG_LSB = 8;
   localparam int ARG_W   = 8;
endpackage

// File: rtl/etm_compare.sv
module etm_compare #(
   parameter int NUM_PORTS = 4,
   parameter int PORT_W    = 8,
   parameter int PSEL_W    = 2
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic [NUM_PORTS*PORT_W-1:0] ports,
   input  logic [2:0]                  op,
   input  logic                        sgn,
   input  logic [PSEL_W-1:0]           psel,
   input  logic [PORT_W-1:0]           operand,
   output logic                        event_q
);
   import etm_pkg::*;

   logic [PORT_W-1:0] chosen;
   logic              chosen_ok;
   logic              is_eq, is_lt, hit;

   always_comb begin
      chosen    = '0;
      chosen_ok = 1'b0;
      for (int p = 0; p < NUM_PORTS; p++) begin
         if (psel == PSEL_W'(p)) begin
            chosen    = ports[p*PORT_W +: PORT_W];
            chosen_ok = 1'b1;
         end
      end
   end

   always_comb begin
      is_eq = (chosen == operand);
      is_lt = sgn ? ($signed(chosen) < $signed(operand)) : (chosen < operand);
      unique case (op)
         OP_EQ:   hit = is_eq;
         OP_NE:   hit = !is_eq;
         OP_LT:   hit = is_lt;
         OP_GT:   hit = !is_lt && !is_eq;
         OP_LE:   hit = is_lt || is_eq;
         OP_GE:   hit = !is_lt;
         default: hit = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) event_q <= 1'b0;
      else     event_q <= hit && chosen_ok;
   end
endmodule

// File: rtl/etm_condition.sv
module etm_condition #(
   parameter int NUM_CMP = 4
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [NUM_CMP-1:0] events,
   input  logic [NUM_CMP-1:0] mask,
   input  logic               or_mode,
   input  logic               invert,
   output logic               rise
);
   logic any_hit, all_hit, level, level_q;

   always_comb begin
      any_hit = |(events & mask);
      all_hit = &(events | ~mask);
      if (mask == '0) level = 1'b0;
      else            level = (or_mode ? any_hit : all_hit) ^ invert;
   end

   always_ff @(posedge clk) begin
      if (rst) level_q <= 1'b0;
      else     level_q <= level;
   end

   assign rise = level && !level_q;
endmodule

// File: rtl/etm_action.sv
module etm_action #(
   parameter int NUM_COND = 2,
   parameter int RATE_W   = 4,
   parameter int PSET_W   = 2,
   parameter int ARG_W    = 8
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic [NUM_COND-1:0]       rise,
   input  logic [2*NUM_COND-1:0]     act_flat,
   input  logic [ARG_W*NUM_COND-1:0] arg_flat,
   output logic [NUM_COND-1:0]       cond_pulse,
   output logic                      rec_active,
   output logic [RATE_W-1:0]         rate_sel,
   output logic [PSET_W-1:0]         pset_sel
);
   import etm_pkg::*;

   logic              start_any, stop_any, rate_hit, pset_hit;
   logic [RATE_W-1:0] rate_nx;
   logic [PSET_W-1:0] pset_nx;
   etm_act_e          kind;

   always_comb begin
      start_any = 1'b0;
      stop_any  = 1'b0;
      rate_hit  = 1'b0;
      pset_hit  = 1'b0;
      rate_nx   = rate_sel;
      pset_nx   = pset_sel;
      kind      = ACT_START;
      // walk downward so the lowest-numbered condition is applied last
      for (int j = NUM_COND - 1; j >= 0; j--) begin
         kind = etm_act_e'(act_flat[2*j +: 2]);
         if (rise[j]) begin
            case (kind)
               ACT_START: start_any = 1'b1;
               ACT_STOP:  stop_any  = 1'b1;
               ACT_RATE: begin
                  rate_hit = 1'b1;
                  rate_nx  = arg_flat[ARG_W*j +: RATE_W];
               end
               default: begin
                  pset_hit = 1'b1;
                  pset_nx  = arg_flat[ARG_W*j +: PSET_W];
               end
            endcase
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cond_pulse <= '0;
         rec_active <= 1'b0;
         rate_sel   <= '0;
         pset_sel   <= '0;
      end else begin
         cond_pulse <= rise;
         if (stop_any)       rec_active <= 1'b0;
         else if (start_any) rec_active <= 1'b1;
         if (rate_hit) rate_sel <= rate_nx;
         if (pset_hit) pset_sel <= pset_nx;
      end
   end
endmodule

// File: rtl/etm_trigger_manager.sv
module etm_trigger_manager #(
   parameter int NUM_PORTS = 4,
   parameter int PORT_W    = 8,
   parameter int NUM_CMP   = 4,
   parameter int NUM_COND  = 2,
   parameter int RATE_W    = 4,
   parameter int PSET_W    = 2,
   parameter int CFG_W     = 16,
   parameter int ADDR_W    = 4
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        cfg_we,
   input  logic [ADDR_W-1:0]           cfg_addr,
   input  logic [CFG_W-1:0]            cfg_wdata,
   input  logic [NUM_PORTS*PORT_W-1:0] mon_ports,
   output logic [NUM_COND-1:0]         cond_pulse,
   output logic                        rec_active,
   output logic [RATE_W-1:0]           rate_sel,
   output logic [PSET_W-1:0]           pset_sel
);
   import etm_pkg::*;

   localparam int PSEL_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
   localparam int CTRL_W    = 4 + PSEL_W;
   localparam int COND_BASE = 2 * NUM_CMP;
   localparam int NUM_REGS  = COND_BASE + NUM_COND;

   if (NUM_CMP < 1 || NUM_CMP > 4) begin : g_bad_cmp
      $error("NUM_CMP must be 1..4 to fit the condition mask field");
   end
   if (CFG_W < ARG_LSB + ARG_W || PORT_W > CFG_W || CTRL_W > CFG_W) begin : g_bad_cfg
      $error("CFG_W too narrow for the register fields");
   end
   if (RATE_W > ARG_W || PSET_W > ARG_W) begin : g_bad_arg
      $error("RATE_W and PSET_W must fit the action argument");
   end
   if (NUM_REGS > (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too small for the register count");
   end

   logic [NUM_CMP-1:0]        events;
   logic [NUM_COND-1:0]       rise;
   logic [2*NUM_COND-1:0]     act_flat;
   logic [ARG_W*NUM_COND-1:0] arg_flat;

   for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
      logic [CTRL_W-1:0] ctrl_q;
      logic [PORT_W-1:0] opnd_q;

      always_ff @(posedge clk) begin
         if (rst) begin
            ctrl_q <= '0;
            opnd_q <= '0;
         end else if (cfg_we) begin
            if (cfg_addr == ADDR_W'(2*i))     ctrl_q <= cfg_wdata[CTRL_W-1:0];
            if (cfg_addr == ADDR_W'(2*i + 1)) opnd_q <= cfg_wdata[PORT_W-1:0];
         end
      end

      etm_compare #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W), .PSEL_W(PSEL_W)) u_cmp (
         .clk     (clk),
         .rst     (rst),
         .ports   (mon_ports),
         .op      (ctrl_q[2:0]),
         .sgn     (ctrl_q[3]),
         .psel    (ctrl_q[4 +: PSEL_W]),
         .operand (opnd_q),
         .event_q (events[i])
      );
   end

   for (genvar j = 0; j < NUM_COND; j++) begin : g_cond
      logic [NUM_CMP-1:0] mask_q;
      logic               or_q, inv_q;
      logic [1:0]         act_q;
      logic [ARG_W-1:0]   arg_q;

      always_ff @(posedge clk) begin
         if (rst) begin
            mask_q <= '0;
            or_q   <= 1'b0;
            inv_q  <= 1'b0;
            act_q  <= '0;
            arg_q  <= '0;
         end else if (cfg_we && cfg_addr == ADDR_W'(COND_BASE + j)) begin
            mask_q <= cfg_wdata[NUM_CMP-1:0];
            or_q   <= cfg_wdata[4];
            inv_q  <= cfg_wdata[5];
            act_q  <= cfg_wdata[7:6];
            arg_q  <= cfg_wdata[ARG_LSB +: ARG_W];
         end
      end

      assign act_flat[2*j +: 2]         = act_q;
      assign arg_flat[ARG_W*j +: ARG_W] = arg_q;

      etm_condition #(.NUM_CMP(NUM_CMP)) u_cond (
         .clk     (clk),
         .rst     (rst),
         .events  (events),
         .mask    (mask_q),
         .or_mode (or_q),
         .invert  (inv_q),
         .rise    (rise[j])
      );
   end

   etm_action #(.NUM_COND(NUM_COND), .RATE_W(RATE_W), .PSET_W(PSET_W), .ARG_W(ARG_W)) u_act (
      .clk        (clk),
      .rst        (rst),
      .rise       (rise),
      .act_flat   (act_flat),
      .arg_flat   (arg_flat),
      .cond_pulse (cond_pulse),
      .rec_active (rec_active),
      .rate_sel   (rate_sel),
      .pset_sel   (pset_sel)
   );
endmodule

// File: rtl/etm_trigger_manager_chk.sv
module etm_trigger_manager_chk #(
   parameter int NUM_COND = 2,
   parameter int RATE_W   = 4,
   parameter int PSET_W   = 2
) (
   input logic                clk,
   input logic                rst,
   input logic [NUM_COND-1:0] cond_pulse,
   input logic                rec_active,
   input logic [RATE_W-1:0]   rate_sel,
   input logic [PSET_W-1:0]   pset_sel
);
   AST_RESET_CLEARS: assert property (@(posedge clk)
      rst |=> (!rec_active && rate_sel == '0 && pset_sel == '0 && cond_pulse == '0)); // R1

   AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
      (cond_pulse & $past(cond_pulse)) == '0); // R7

   AST_REC_START_CAUSED: assert property (@(posedge clk) disable iff (rst)
      $rose(rec_active) |-> (cond_pulse != '0)); // R9

   AST_RATE_CHANGE_CAUSED: assert property (@(posedge clk) disable iff (rst)
      !$stable(rate_sel) |-> (cond_pulse != '0)); // R10

   AST_PSET_CHANGE_CAUSED: assert property (@(posedge clk) disable iff (rst)
      !$stable(pset_sel) |-> (cond_pulse != '0)); // R11
endmodule

bind etm_trigger_manager etm_trigger_manager_chk #(
   .NUM_COND(NUM_COND), .RATE_W(RATE_W), .PSET_W(PSET_W)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .cond_pulse (cond_pulse),
   .rec_active (rec_active),
   .rate_sel   (rate_sel),
   .pset_sel   (pset_sel)
);

// File: tb/etm_trigger_manager_test.sv
module etm_trigger_manager_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cfg_we = 1'b0;
   logic [3:0]  cfg_addr = '0;
   logic [15:0] cfg_wdata = '0;
   logic [31:0] mon = '0;
   logic [1:0]  cond_pulse;
   logic        rec_active;
   logic [3:0]  rate_sel;
   logic [1:0]  pset_sel;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   etm_trigger_manager uut (
      .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .mon_ports(mon), .cond_pulse(cond_pulse),
      .rec_active(rec_active), .rate_sel(rate_sel), .pset_sel(pset_sel)
   );

   function automatic logic [15:0] cmpw(int op, int sgn, int psel);
      return 16'(op | (sgn << 3) | (psel << 4));
   endfunction

   function automatic logic [15:0] condw(int mask, int orm, int inv, int act, int arg);
      return 16'(mask | (orm << 4) | (inv << 5) | (act << 6) | (arg << 8));
   endfunction

   task automatic chk(bit ok, string req, string what, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic wr(int addr, logic [15:0] data);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = 4'(addr); cfg_wdata = data;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic idle(int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic set_port(int p, int v);
      @(negedge clk);
      mon[8*p +: 8] = 8'(v);
   endtask

   task automatic count_pulses(int n, output int cnt);
      cnt = 0;
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         if (cond_pulse[0]) cnt++;
      end
   endtask

   // wait two edges after a stimulus at a negedge, sample at next negedge
   task automatic two_edges();
      @(posedge clk); @(posedge clk); @(negedge clk);
   endtask

   task automatic t_op(int op, int sgn, int pv, int opnd, bit exp, string req);
      mon[7:0] = 8'(pv);
      wr(1, 16'(opnd));
      wr(0, cmpw(0, 0, 0));
      idle(3);
      wr(0, cmpw(op, sgn, 0));
      @(posedge clk); @(posedge clk); @(negedge clk);
      chk(cond_pulse[0] == exp, req, $sformatf("op %0d sgn %0d %0d vs %0d", op, sgn, pv, opnd),
          int'(cond_pulse[0]), int'(exp));
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(rec_active == 0 && rate_sel == 0 && pset_sel == 0 && cond_pulse == 0, "R1",
          "outputs in reset", int'({rec_active, rate_sel, pset_sel, cond_pulse}), 0);
      @(negedge clk); rst = 1'b0;
      idle(3);
      chk(rec_active == 0 && rate_sel == 0 && pset_sel == 0 && cond_pulse == 0, "R1",
          "outputs after reset", int'({rec_active, rate_sel, pset_sel, cond_pulse}), 0);
   endtask

   task automatic t_opcodes();
      wr(8, condw(1, 0, 0, 2, 5));
      wr(9, 16'h0000);
      t_op(1, 0, 50, 50, 1'b1, "R2");
      t_op(2, 0, 50, 50, 1'b0, "R2");
      t_op(2, 0, 51, 50, 1'b1, "R2");
      t_op(3, 0, 40, 50, 1'b1, "R2");
      t_op(3, 0, 50, 50, 1'b0, "R2");
      t_op(4, 0, 40, 50, 1'b0, "R2");
      t_op(4, 0, 60, 50, 1'b1, "R2");
      t_op(5, 0, 50, 50, 1'b1, "R2");
      t_op(5, 0, 51, 50, 1'b0, "R2");
      t_op(6, 0, 49, 50, 1'b0, "R2");
      t_op(6, 0, 50, 50, 1'b1, "R2");
      t_op(7, 0, 50, 50, 1'b0, "R2");
      t_op(3, 1, 8'hF0, 8'h10, 1'b1, "R3");
      t_op(3, 0, 8'hF0, 8'h10, 1'b0, "R3");
      t_op(4, 1, 8'h10, 8'hF0, 1'b1, "R3");
   endtask

   task automatic t_portsel();
      mon = '0;
      mon[23:16] = 8'h77;
      wr(1, 16'h0077);
      wr(0, cmpw(0, 0, 0));
      idle(3);
      wr(0, cmpw(1, 0, 2));
      two_edges();
      chk(cond_pulse[0] == 1'b1, "R4", "port 2 selected", int'(cond_pulse[0]), 1);
      chk(rate_sel == 4'd5, "R4", "rate after port 2 match", int'(rate_sel), 5);
   endtask

   task automatic t_and_or();
      int cnt;
      mon = '0;
      wr(0, cmpw(1, 0, 0)); wr(1, 16'h0011);
      wr(2, cmpw(1, 0, 1)); wr(3, 16'h0022);
      wr(8, condw(3, 0, 0, 2, 6));
      idle(3);
      set_port(0, 8'h11);
      count_pulses(4, cnt);
      chk(cnt == 0, "R5", "AND with one event", cnt, 0);
      set_port(1, 8'h22);
      @(posedge clk); @(negedge clk);
      chk(cond_pulse[0] == 1'b0, "R8", "no pulse after one edge", int'(cond_pulse[0]), 0);
      @(posedge clk); @(negedge clk);
      chk(cond_pulse[0] == 1'b1, "R8", "pulse after two edges", int'(cond_pulse[0]), 1);
      chk(rate_sel == 4'd6, "R5", "AND both events rate", int'(rate_sel), 6);
      mon = '0;
      wr(8, condw(3, 1, 0, 2, 4));
      idle(3);
      set_port(1, 8'h22);
      two_edges();
      chk(cond_pulse[0] == 1'b1 && rate_sel == 4'd4, "R5", "OR one event rate", int'(rate_sel), 4);
      count_pulses(10, cnt);
      chk(cnt == 0, "R7", "held condition pulses", cnt, 0);
      set_port(1, 0);
      idle(3);
      set_port(0, 8'h11);
      count_pulses(4, cnt);
      chk(cnt == 1, "R7", "second rise pulses", cnt, 1);
   endtask

   task automatic t_mask_invert();
      int cnt;
      mon = '0;
      idle(2);
      wr(8, condw(0, 0, 1, 2, 9));
      count_pulses(6, cnt);
      chk(cnt == 0, "R5", "empty mask inverted pulses", cnt, 0);
      chk(rate_sel == 4'd4, "R5", "empty mask rate", int'(rate_sel), 4);
      wr(8, condw(1, 0, 1, 2, 12));
      idle(3);
      chk(rate_sel == 4'd12, "R6", "inverted false event fires", int'(rate_sel), 12);
      set_port(0, 8'h11);
      count_pulses(4, cnt);
      chk(cnt == 0, "R6", "inverted true event quiet", cnt, 0);
   endtask

   task automatic t_record();
      mon = '0;
      wr(8, condw(1, 0, 0, 0, 0));
      wr(9, condw(2, 0, 0, 1, 0));
      idle(3);
      set_port(0, 8'h11); two_edges();
      chk(rec_active == 1'b1, "R9", "start", int'(rec_active), 1);
      set_port(1, 8'h22); two_edges();
      chk(rec_active == 1'b0, "R9", "stop", int'(rec_active), 0);
      mon = '0; idle(3);
      set_port(0, 8'h11); two_edges();
      chk(rec_active == 1'b1, "R9", "restart", int'(rec_active), 1);
      set_port(0, 0);
      wr(9, condw(1, 0, 0, 1, 0));
      idle(3);
      set_port(0, 8'h11); two_edges();
      chk(rec_active == 1'b0, "R9", "stop beats start", int'(rec_active), 0);
   endtask

   task automatic t_rate_pset();
      mon = '0;
      wr(8, condw(1, 0, 0, 2, 3));
      wr(9, condw(1, 0, 0, 2, 9));
      idle(3);
      set_port(0, 8'h11); two_edges();
      chk(cond_pulse == 2'b11, "R10", "both pulses", int'(cond_pulse), 3);
      chk(rate_sel == 4'd3, "R10", "lowest index wins rate", int'(rate_sel), 3);
      mon = '0;
      wr(8, condw(1, 0, 0, 3, 2));
      wr(9, condw(1, 0, 0, 3, 1));
      idle(3);
      set_port(0, 8'h11);
      @(posedge clk); @(negedge clk);
      chk(pset_sel == 2'd0, "R11", "pset before action edge", int'(pset_sel), 0);
      @(posedge clk); @(negedge clk);
      chk(pset_sel == 2'd2, "R11", "lowest index wins pset", int'(pset_sel), 2);
   endtask

   task automatic t_unmapped();
      int cnt;
      wr(8, 16'h0000);
      wr(9, 16'h0000);
      idle(3);
      for (int a = 10; a < 16; a++) wr(a, 16'h079F);
      count_pulses(5, cnt);
      chk(cnt == 0 && cond_pulse[1] == 1'b0, "R12", "pulses after unmapped writes", cnt, 0);
      chk(rate_sel == 4'd3 && pset_sel == 2'd2, "R12", "rate after unmapped writes", int'(rate_sel), 3);
   endtask

   initial begin
      t_reset();
      t_opcodes();
      t_portsel();
      t_and_or();
      t_mask_invert();
      t_record();
      t_rate_pset();
      t_unmapped();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #2000000;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule